// File: doc/BRIEF.md
# UDP Frame Classifier and Router

This block sits behind the receive side of an Ethernet port. It takes error-free frames as a byte stream and sends each one whole to one of three destinations: a command path for board register access, a data path for the application buffer, or a general path for the protocol stack. The choice depends on the Ethernet type, the IPv4 header and the UDP destination port. This lets register traffic and data traffic share one UDP interface, while ARP, DHCP, fragmented datagrams and malformed packets fall through to the stack.

The first 38 bytes of a frame, up to and including the UDP destination port, are collected into a small header store. The route is then fixed and the stored bytes are replayed to the chosen output. The rest of the frame then passes straight through, with back-pressure from that output, until end-of-frame. Only after that end-of-frame has left the block does collection of the next frame begin.

Top module: `udp_frame_router`

## Requirements
- R1: Each frame appears complete on exactly one output, and at most one bit of `out_valid` is high in any cycle. The route code is the bit index of `out_valid`: 0 = command, 1 = data, 2 = other.
- R2: A frame goes to command or data only if it carries Ethernet type 0x0800 at byte offsets 12..13 and IP protocol 17 at offset 23. Type 0x0806 (ARP) and any non-UDP protocol go to other.
- R3: For a UDP frame that passes every check, a destination port (offsets 36..37, big-endian) equal to `CMD_PORT` selects command and one equal to `DATA_PORT` selects data. Any other port, including DHCP port 67, selects other.
- R4: A packet with the more-fragments flag (bit 5 of offset 20) set, or a nonzero fragment offset (low 5 bits of offset 20 together with offset 21), goes to other.
- R5: The version/header-length byte at offset 14 must be 0x45. Any other value, such as 0x46 for a header with options, routes to other.
- R6: The IP total length (offsets 16..17) must lie in `MIN_IP_LEN`..`MAX_IP_LEN` inclusive (defaults 46 and 1500). Values outside that range route to other.
- R7: The output reproduces the input frame byte for byte and in order, header bytes included. `out_sof` is on the first byte and `out_eof` on the last.
- R8: A frame that ends before 38 bytes have been received routes to other and is forwarded complete.
- R9: No byte is lost or duplicated while the selected output deasserts ready. `in_ready` is low while the route is being decided and while the header is replayed.
- R10: After reset, `out_valid` is all zero and `in_ready` is high.
- R11: The route is held from the decision until the frame's end-of-frame is forwarded. A frame that follows immediately is classified on its own header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| out_valid | output | 3 | Per-destination valid (bit 0 command, 1 data, 2 other) |
| out_ready | input | 3 | Per-destination ready |
| out_data | output | 8 | Output byte, shared by all destinations |
| out_sof | output | 1 | First byte of the forwarded frame |
| out_eof | output | 1 | Last byte of the forwarded frame |

## Verification
An input byte counts as taken at the rising edge where `in_valid` and `in_ready` are both high. The route register loads one cycle after the 38th header byte (or the early end-of-frame) is taken. The first replayed byte is visible in the cycle after that, and each later byte follows one cycle after its output handshake. Bytes in the pass-through phase appear on the output in the same cycle they are offered. The bench drives inputs just after the rising edge and samples handshakes at the falling edge. It collects each output frame in full before comparing destination, length and every byte against a frame it built itself, so its checks do not depend on a fixed latency.

// File: rtl/udp_router_pkg.sv
package udp_router_pkg;
  typedef enum logic [1:0] {
    ROUTE_CMD   = 2'd0,
    ROUTE_DATA  = 2'd1,
    ROUTE_OTHER = 2'd2
  } route_e;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_DECIDE  = 2'd1,
    ST_REPLAY  = 2'd2,
    ST_PASS    = 2'd3
  } state_e;

  localparam int ETH_HDR_BYTES  = 14;
  localparam int IP_HDR_BYTES   = 20;
  localparam int UDP_DPORT_END  = 4;
  localparam int OFS_ETYPE      = 12;
  localparam int OFS_VIHL       = ETH_HDR_BYTES;
  localparam int OFS_TLEN       = ETH_HDR_BYTES + 2;
  localparam int OFS_FRAG       = ETH_HDR_BYTES + 6;
  localparam int OFS_PROTO      = ETH_HDR_BYTES + 9;
  localparam int OFS_DPORT      = ETH_HDR_BYTES + IP_HDR_BYTES + 2;
  localparam int HDR_BYTES      = ETH_HDR_BYTES + IP_HDR_BYTES + UDP_DPORT_END;
  localparam int NUM_ROUTES     = 3;
endpackage

// File: rtl/hdr_buf.sv
module hdr_buf #(
  parameter int DEPTH = udp_router_pkg::HDR_BYTES,
  parameter int AW    = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [AW-1:0]        rd_idx,
  output logic [7:0]           rd_data,
  output logic [DEPTH*8-1:0]   flat
);
  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == AW'(g));
    always_ff @(posedge clk) begin
      if (hit) mem[g] <= wr_data;
    end
    assign flat[g*8 +: 8] = mem[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == AW'(i)) rd_data = mem[i];
    end
  end
endmodule

// File: rtl/route_decide.sv
module route_decide
  import udp_router_pkg::*;
#(
  parameter int          DEPTH      = HDR_BYTES,
  parameter logic [15:0] CMD_PORT   = 16'd7001,
  parameter logic [15:0] DATA_PORT  = 16'd7002,
  parameter logic [15:0] MIN_IP_LEN = 16'd46,
  parameter logic [15:0] MAX_IP_LEN = 16'd1500
) (
  input  logic [DEPTH*8-1:0] hdr,
  input  logic               hdr_full,
  output route_e             route
);
  logic [15:0] etype, tlen, frag, dport;
  logic [7:0]  vihl, proto;
  logic        is_ipv4, is_udp, no_frag, len_ok, hdr_ok, eligible;

  assign etype = {hdr[OFS_ETYPE*8 +: 8],     hdr[(OFS_ETYPE+1)*8 +: 8]};
  assign tlen  = {hdr[OFS_TLEN*8 +: 8],      hdr[(OFS_TLEN+1)*8 +: 8]};
  assign frag  = {hdr[OFS_FRAG*8 +: 8],      hdr[(OFS_FRAG+1)*8 +: 8]};
  assign dport = {hdr[OFS_DPORT*8 +: 8],     hdr[(OFS_DPORT+1)*8 +: 8]};
  assign vihl  = hdr[OFS_VIHL*8 +: 8];
  assign proto = hdr[OFS_PROTO*8 +: 8];

  assign is_ipv4  = (etype == 16'h0800);
  assign hdr_ok   = (vihl == 8'h45);
  assign is_udp   = (proto == 8'd17);
  assign no_frag  = (frag[13] == 1'b0) && (frag[12:0] == 13'd0);
  assign len_ok   = (tlen >= MIN_IP_LEN) && (tlen <= MAX_IP_LEN);
  assign eligible = hdr_full && is_ipv4 && hdr_ok && is_udp && no_frag && len_ok;

  always_comb begin
    route = ROUTE_OTHER;
    if (eligible && dport == CMD_PORT)       route = ROUTE_CMD;
    else if (eligible && dport == DATA_PORT) route = ROUTE_DATA;
  end
endmodule

// File: rtl/udp_frame_router.sv
module udp_frame_router
  import udp_router_pkg::*;
#(
  parameter logic [15:0] CMD_PORT   = 16'd7001,
  parameter logic [15:0] DATA_PORT  = 16'd7002,
  parameter logic [15:0] MIN_IP_LEN = 16'd46,
  parameter logic [15:0] MAX_IP_LEN = 16'd1500
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [7:0]            in_data,
  input  logic                  in_sof,
  input  logic                  in_eof,
  output logic [NUM_ROUTES-1:0] out_valid,
  input  logic [NUM_ROUTES-1:0] out_ready,
  output logic [7:0]            out_data,
  output logic                  out_sof,
  output logic                  out_eof
);
  localparam int AW = $clog2(HDR_BYTES + 1);
  localparam logic [AW-1:0] LAST_HDR = AW'(HDR_BYTES - 1);
  localparam logic [AW-1:0] FULL_HDR = AW'(HDR_BYTES);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  state_e          st_q, st_d;
  route_e          sel_q, sel_d, route_w;
  logic [AW-1:0]   cnt_q, cnt_d, rd_q, rd_d;
  logic            eof_q, eof_d;
  logic            in_hs, out_hs, sel_rdy, buf_wr, replay_last;
  logic [7:0]      buf_rd;
  logic [HDR_BYTES*8-1:0] hdr_flat;

  hdr_buf #(.DEPTH(HDR_BYTES), .AW(AW)) u_buf (
    .clk     (clk),
    .wr_en   (buf_wr),
    .wr_idx  (cnt_q),
    .wr_data (in_data),
    .rd_idx  (rd_q),
    .rd_data (buf_rd),
    .flat    (hdr_flat)
  );

  route_decide #(
    .DEPTH(HDR_BYTES), .CMD_PORT(CMD_PORT), .DATA_PORT(DATA_PORT),
    .MIN_IP_LEN(MIN_IP_LEN), .MAX_IP_LEN(MAX_IP_LEN)
  ) u_decide (
    .hdr      (hdr_flat),
    .hdr_full (cnt_q == FULL_HDR),
    .route    (route_w)
  );

  assign sel_rdy     = out_ready[sel_q];
  assign replay_last = (rd_q == cnt_q - AW'(1));

  // Output and handshake steering
  always_comb begin
    in_ready  = 1'b0;
    out_valid = '0;
    out_data  = buf_rd;
    out_sof   = 1'b0;
    out_eof   = 1'b0;
    unique case (st_q)
      ST_COLLECT: in_ready = 1'b1;
      ST_DECIDE:  in_ready = 1'b0;
      ST_REPLAY: begin
        out_valid[sel_q] = 1'b1;
        out_sof          = (rd_q == '0);
        out_eof          = eof_q && replay_last;
      end
      ST_PASS: begin
        in_ready         = sel_rdy;
        out_valid[sel_q] = in_valid;
        out_data         = in_data;
        out_eof          = in_eof;
      end
      default: in_ready = 1'b0;
    endcase
  end

  assign in_hs  = in_valid && in_ready;
  assign out_hs = |(out_valid & out_ready);
  assign buf_wr = in_hs && (st_q == ST_COLLECT);

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    cnt_d = cnt_q;
    rd_d  = rd_q;
    eof_d = eof_q;
    unique case (st_q)
      ST_COLLECT: begin
        if (in_hs) begin
          cnt_d = cnt_q + AW'(1);
          if (in_eof) begin
            eof_d = 1'b1;
            st_d  = ST_DECIDE;
          end else if (cnt_q == LAST_HDR) begin
            st_d = ST_DECIDE;
          end
        end
      end
      ST_DECIDE: begin
        sel_d = route_w;
        rd_d  = '0;
        st_d  = ST_REPLAY;
      end
      ST_REPLAY: begin
        if (out_hs) begin
          rd_d = rd_q + AW'(1);
          if (replay_last) begin
            if (eof_q) begin
              st_d  = ST_COLLECT;
              cnt_d = '0;
              eof_d = 1'b0;
            end else begin
              st_d = ST_PASS;
            end
          end
        end
      end
      ST_PASS: begin
        if (in_hs && in_eof) begin
          st_d  = ST_COLLECT;
          cnt_d = '0;
        end
      end
      default: st_d = ST_COLLECT;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      st_q  <= ST_COLLECT;
      sel_q <= ROUTE_OTHER;
      cnt_q <= '0;
      rd_q  <= '0;
      eof_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
      eof_q <= eof_d;
    end
  end

  // Assertions
  assert_single_dest_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(out_valid));

  assert_hold_route_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (st_q != ST_DECIDE) |=> $stable(sel_q));

  assert_no_input_while_replay_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (st_q == ST_DECIDE || st_q == ST_REPLAY) |-> !in_ready);

  assert_pass_forward_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (st_q == ST_PASS && in_hs) |-> (out_hs && out_data == in_data && out_eof == in_eof));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    cnt_q <= FULL_HDR);

  assert_silent_collect_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (st_q == ST_COLLECT) |-> (out_valid == '0));
endmodule

// File: tb/tb_udp_frame_router.sv
module tb_udp_frame_router;
  localparam logic [15:0] CMD_P  = 16'd7001;
  localparam logic [15:0] DATA_P = 16'd7002;
  localparam int NV = 13;

  // {etype, vihl, tlen, flags, foff, proto, dport, nbytes, route}
  localparam logic [97:0] VEC [NV] = '{
    {16'h0800, 8'h45, 16'd100,  8'h00, 8'h00, 8'd17, CMD_P,   16'd64, 2'd0}, // R3 cmd
    {16'h0800, 8'h45, 16'd100,  8'h00, 8'h00, 8'd17, DATA_P,  16'd64, 2'd1}, // R3 data
    {16'h0800, 8'h45, 16'd100,  8'h00, 8'h00, 8'd17, 16'd999, 16'd64, 2'd2}, // R3 other port
    {16'h0806, 8'h45, 16'd100,  8'h00, 8'h00, 8'd17, CMD_P,   16'd60, 2'd2}, // R2 ARP
    {16'h0800, 8'h45, 16'd300,  8'h00, 8'h00, 8'd17, 16'd67,  16'd70, 2'd2}, // R3 DHCP
    {16'h0800, 8'h45, 16'd100,  8'h20, 8'h00, 8'd17, CMD_P,   16'd64, 2'd2}, // R4 MF
    {16'h0800, 8'h45, 16'd100,  8'h00, 8'h01, 8'd17, DATA_P,  16'd64, 2'd2}, // R4 offset
    {16'h0800, 8'h46, 16'd100,  8'h00, 8'h00, 8'd17, CMD_P,   16'd64, 2'd2}, // R5 IHL
    {16'h0800, 8'h45, 16'd45,   8'h00, 8'h00, 8'd17, CMD_P,   16'd60, 2'd2}, // R6 too short
    {16'h0800, 8'h45, 16'd46,   8'h00, 8'h00, 8'd17, CMD_P,   16'd60, 2'd0}, // R6 min
    {16'h0800, 8'h45, 16'd1500, 8'h00, 8'h00, 8'd17, DATA_P,  16'd90, 2'd1}, // R6 max
    {16'h0800, 8'h45, 16'd1501, 8'h00, 8'h00, 8'd17, DATA_P,  16'd90, 2'd2}, // R6 too long
    {16'h0800, 8'h45, 16'd100,  8'h00, 8'h00, 8'd6,  CMD_P,   16'd64, 2'd2}  // R2 TCP
  };

  logic       clk, rst_n;
  logic       in_valid, in_ready, in_sof, in_eof;
  logic [7:0] in_data;
  logic [2:0] out_valid, out_ready;
  logic [7:0] out_data;
  logic       out_sof, out_eof;

  udp_frame_router #(.CMD_PORT(CMD_P), .DATA_PORT(DATA_P)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] txb [8][256];
  int         txn [8];
  int         tx_count = 0;
  logic [7:0] rxb [8][256];
  int         rxn [8];
  int         rxp [8];
  int         rx_count = 0;
  int         rx_pos = 0;
  int         cur_port = 0;
  logic       stall = 1'b0;
  int         cyc = 0;

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Ready pattern generator
  always @(posedge clk) begin
    #1;
    cyc++;
    if (stall) out_ready = {cyc[1], cyc[0] ^ cyc[2], ~cyc[1] | cyc[0]};
    else       out_ready = 3'b111;
  end

  // Output monitor: handshakes sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < 3; p++) begin
        if (out_valid[p] && out_ready[p]) begin
          if (out_sof) begin
            rx_pos   = 0;
            cur_port = p;
          end
          rxb[rx_count % 8][rx_pos] = out_data;
          rx_pos++;
          if (out_eof) begin
            rxn[rx_count % 8] = rx_pos;
            rxp[rx_count % 8] = cur_port;
            rx_count++;
          end
        end
      end
    end
  end

  task automatic build(input logic [97:0] v);
    int s;
    int n;
    s = tx_count % 8;
    n = int'(v[17:2]);
    for (int i = 0; i < n; i++) txb[s][i] = 8'(i * 13 + tx_count * 7 + 1);
    if (n > 13) begin txb[s][12] = v[97:90]; txb[s][13] = v[89:82]; end
    if (n > 14) txb[s][14] = v[81:74];
    if (n > 17) begin txb[s][16] = v[73:66]; txb[s][17] = v[65:58]; end
    if (n > 21) begin txb[s][20] = v[57:50]; txb[s][21] = v[49:42]; end
    if (n > 23) txb[s][23] = v[41:34];
    if (n > 37) begin txb[s][36] = v[33:26]; txb[s][37] = v[25:18]; end
    txn[s] = n;
  endtask

  task automatic send();
    int s;
    s = tx_count % 8;
    for (int i = 0; i < txn[s]; i++) begin
      in_valid = 1'b1;
      in_data  = txb[s][i];
      in_sof   = (i == 0);
      in_eof   = (i == txn[s] - 1);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
    tx_count++;
  endtask

  task automatic wait_rx(input int target);
    for (int i = 0; i < 4000 && rx_count < target; i++) @(posedge clk);
  endtask

  task automatic check_frame(input int idx, input int exp_route, input string req);
    int s;
    int bad;
    s = idx % 8;
    check(rx_count > idx, req, rx_count, idx + 1);
    if (rx_count > idx) begin
      check(rxp[s] == exp_route, req, rxp[s], exp_route);
      check(rxn[s] == txn[s], "R7", rxn[s], txn[s]);
      bad = 0;
      for (int i = 0; i < txn[s]; i++) if (rxb[s][i] !== txb[s][i]) bad++;
      check(bad == 0, "R7", bad, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_up();
  end

  initial begin
    in_valid  = 1'b0;
    in_sof    = 1'b0;
    in_eof    = 1'b0;
    in_data   = 8'h00;
    out_ready = 3'b111;
    rst_n     = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R10: idle after reset
    @(negedge clk);
    check(out_valid == 3'b000, "R10", int'(out_valid), 0);
    check(in_ready == 1'b1, "R10", int'(in_ready), 1);
    @(posedge clk); #1;

    // Table of vectors (R2..R6, R7 byte integrity)
    for (int k = 0; k < NV; k++) begin
      build(VEC[k]);
      send();
      wait_rx(tx_count);
      case (k)
        3, 12:         check_frame(tx_count - 1, int'(VEC[k][1:0]), "R2");
        0, 1, 2, 4:    check_frame(tx_count - 1, int'(VEC[k][1:0]), "R3");
        5, 6:          check_frame(tx_count - 1, int'(VEC[k][1:0]), "R4");
        7:             check_frame(tx_count - 1, int'(VEC[k][1:0]), "R5");
        default:       check_frame(tx_count - 1, int'(VEC[k][1:0]), "R6");
      endcase
    end

    // R8: frame ending inside the header goes to other, complete
    build({16'h0800, 8'h45, 16'd100, 8'h00, 8'h00, 8'd17, CMD_P, 16'd20, 2'd2});
    send();
    wait_rx(tx_count);
    check_frame(tx_count - 1, 2, "R8");

    // R8: single-byte frame
    build({16'h0800, 8'h45, 16'd100, 8'h00, 8'h00, 8'd17, CMD_P, 16'd1, 2'd2});
    send();
    wait_rx(tx_count);
    check_frame(tx_count - 1, 2, "R8");

    // R7: frame ending exactly on the last header byte is still classified
    build({16'h0800, 8'h45, 16'd46, 8'h00, 8'h00, 8'd17, CMD_P, 16'd38, 2'd0});
    send();
    wait_rx(tx_count);
    check_frame(tx_count - 1, 0, "R7");

    // R11: back-to-back frames with different routes
    build({16'h0800, 8'h45, 16'd200, 8'h00, 8'h00, 8'd17, DATA_P, 16'd80, 2'd1});
    send();
    build({16'h0800, 8'h45, 16'd200, 8'h00, 8'h00, 8'd17, CMD_P, 16'd50, 2'd0});
    send();
    wait_rx(tx_count);
    check_frame(tx_count - 2, 1, "R11");
    check_frame(tx_count - 1, 0, "R11");

    // R9: irregular output ready on every destination
    stall = 1'b1;
    build({16'h0800, 8'h45, 16'd500, 8'h00, 8'h00, 8'd17, CMD_P, 16'd120, 2'd0});
    send();
    build({16'h0800, 8'h45, 16'd500, 8'h00, 8'h00, 8'd17, DATA_P, 16'd120, 2'd1});
    send();
    build({16'h0806, 8'h45, 16'd500, 8'h00, 8'h00, 8'd17, DATA_P, 16'd100, 2'd2});
    send();
    wait_rx(tx_count);
    check_frame(tx_count - 3, 0, "R9");
    check_frame(tx_count - 2, 1, "R9");
    check_frame(tx_count - 1, 2, "R9");
    stall = 1'b0;

    // R1: every frame sent came out exactly once
    repeat (10) @(posedge clk);
    check(rx_count == tx_count, "R1", rx_count, tx_count);

    finish_up();
  end
endmodule